// File: doc/BRIEF.md
# Pipelined Cache Program Controller

This block sits on the host side of a NAND flash device and writes a run of consecutive pages into a single block, using the device's cache program mode. A page is handed over to the cache register while the array is still programming the page before it. The controller therefore waits only for the cache register to become free between pages. It waits for the array itself to finish only after the final page.

A run begins with a one-cycle `start` pulse that carries a block number, a first page and a page count. The controller first checks that the run fits inside the block. It then takes a byte stream over a valid/ready interface, one full page per page. For each page it drives a command/address/data sequence on a simple strobed bus. After each confirm it polls the status register. At the end it reports done together with a pass/fail result.

Back-pressure on the byte stream works as follows. `s_ready` is high only while a page's data phase is open. A byte is taken on any cycle where `s_valid` and `s_ready` are both high. The source must hold `s_data` steady until the byte is taken, and it may drop `s_valid` at any time.

The bus has one transfer per clock. On a write cycle `nand_we` is high, and `nand_cle` or `nand_ale` marks the cycle as a command or an address. On a read cycle `nand_re` is high, and the device presents the status byte on `nand_din` in the following cycle.

Top module: `cpc_cache_prog`

## Requirements
- R1: After reset, `busy`, `done`, `reject`, `run_fail`, `err_sticky`, `s_ready` and all four bus strobes are low.
- R2: Every page opens with a command write of 0x80 followed by five address writes. The first two address bytes are zero (column). The next three carry the row `block*PAGES_PER_BLOCK + page`, least significant byte first.
- R3: After the address writes, exactly `PAGE_BYTES` data writes follow. Each carries one stream byte, in stream order, on a cycle where `s_valid && s_ready`. `s_ready` is high only in this phase, so a byte the source offers at any other time is not taken.
- R4: Every page except the last of the run is confirmed with command 0x15. The last page is confirmed with 0x10.
- R5: After a 0x15 confirm, the controller writes command 0x70 and reads status until bit 6 (cache ready) is 1. It starts the next page only after that. Bit 5 is not looked at here.
- R6: After a 0x10 confirm, the controller writes 0x70 and reads status until bit 5 (array ready) is 1. It then pulses `done` for one cycle and drops `busy`.
- R7: The page number rises by one for each successive page of a run.
- R8: A start is rejected when the page count is 0 or when start page plus count exceeds `PAGES_PER_BLOCK`. A rejected start raises `reject` for exactly one cycle, on the cycle after the start pulse, and causes no bus activity.
- R9: If bit 0 or bit 1 is set in any status byte that the controller accepts, `run_fail` is 1 when `done` pulses. `run_fail` is cleared at the next accepted start. The same condition sets `err_sticky`, which stays set until reset.
- R10: A `start` pulse while `busy` is high has no effect on the bus sequence of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| start_block | input | BLOCK_W | Target block |
| start_page | input | log2(PAGES_PER_BLOCK) | First page in the block |
| page_count | input | log2(PAGES_PER_BLOCK)+1 | Number of pages in the run |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high together with s_valid |
| s_data | input | 8 | Stream byte |
| nand_cle | output | 1 | Current write is a command |
| nand_ale | output | 1 | Current write is an address byte |
| nand_we | output | 1 | Write strobe for nand_dout |
| nand_re | output | 1 | Status read strobe |
| nand_dout | output | 8 | Byte driven to the device |
| nand_din | input | 8 | Status byte, valid the cycle after nand_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| run_fail | output | 1 | Fail result of the last run |
| err_sticky | output | 1 | Any fail seen since reset |
| reject | output | 1 | One-cycle pulse for an illegal start |

## Verification
The assertions assume the device answers a read in the cycle after `nand_re`. They also assume it raises cache ready only after each 0x15 confirm has been accepted. The bench device model meets both assumptions: it updates `nand_din` on the clock edge where `nand_re` is sampled, and it holds cache ready low for a set number of polls after every confirm. Stimulus changes only on falling clock edges. The stream source inserts gaps in `s_valid` on a fixed pattern, which exercises back-pressure without breaking the hold rule.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_CONF, ST_SCMD, ST_SRD, ST_SCHK
  } cpc_state_e;

  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_CACHE_GO = 8'h15;
  localparam logic [7:0] OP_FINAL_GO = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;

  localparam int SB_CACHE_RDY = 6;
  localparam int SB_ARRAY_RDY = 5;
  localparam int SB_FAIL_PREV = 1;
  localparam int SB_FAIL_CUR  = 0;
  localparam int ADDR_CYCLES  = 5;
endpackage

// File: rtl/cpc_addr_gen.sv
module cpc_addr_gen #(
  parameter int ROW_W = 19
) (
  input  logic [2:0]       idx,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       abyte
);
  logic [23:0] row_ext;
  assign row_ext = 24'(row);

  always_comb begin
    case (idx)
      3'd2:    abyte = row_ext[7:0];
      3'd3:    abyte = row_ext[15:8];
      3'd4:    abyte = row_ext[23:16];
      default: abyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/cpc_status_eval.sv
module cpc_status_eval
  import cpc_pkg::*;
(
  input  logic [7:0] status,
  input  logic       final_pg,
  output logic       ready,
  output logic       fail_seen
);
  assign ready     = final_pg ? status[SB_ARRAY_RDY] : status[SB_CACHE_RDY];
  assign fail_seen = status[SB_FAIL_CUR] | status[SB_FAIL_PREV];
endmodule

// File: rtl/cpc_cache_prog.sv
module cpc_cache_prog
  import cpc_pkg::*;
#(
  parameter int PAGE_BYTES      = 8640,
  parameter int PAGES_PER_BLOCK = 128,
  parameter int BLOCK_W         = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [BLOCK_W-1:0]                  start_block,
  input  logic [$clog2(PAGES_PER_BLOCK)-1:0]  start_page,
  input  logic [$clog2(PAGES_PER_BLOCK):0]    page_count,
  input  logic                                s_valid,
  output logic                                s_ready,
  input  logic [7:0]                          s_data,
  output logic                                nand_cle,
  output logic                                nand_ale,
  output logic                                nand_we,
  output logic                                nand_re,
  output logic [7:0]                          nand_dout,
  input  logic [7:0]                          nand_din,
  output logic                                busy,
  output logic                                done,
  output logic                                run_fail,
  output logic                                err_sticky,
  output logic                                reject
);
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK);
  localparam int CNT_W  = PG_W + 1;
  localparam int ROW_W  = BLOCK_W + PG_W;
  localparam int BYTE_W = $clog2(PAGE_BYTES + 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W:0]    PG_LIMIT  = (CNT_W+1)'(PAGES_PER_BLOCK);

  cpc_state_e          state;
  logic [BLOCK_W-1:0]  block_q;
  logic [PG_W-1:0]     page_q;
  logic [CNT_W-1:0]    left_q;
  logic [2:0]          aidx;
  logic [BYTE_W-1:0]   bcnt;
  logic                last_pg;
  logic                start_ok;
  logic [CNT_W:0]      end_pg;
  logic [7:0]          addr_byte;
  logic                st_ready;
  logic                st_fail;

  assign end_pg   = (CNT_W+1)'(start_page) + (CNT_W+1)'(page_count);
  assign start_ok = (page_count != '0) && (end_pg <= PG_LIMIT);
  assign last_pg  = (left_q == CNT_W'(1));

  cpc_addr_gen #(.ROW_W(ROW_W)) u_addr (
    .idx   (aidx),
    .row   ({block_q, page_q}),
    .abyte (addr_byte)
  );

  cpc_status_eval u_stat (
    .status    (nand_din),
    .final_pg  (last_pg),
    .ready     (st_ready),
    .fail_seen (st_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      block_q    <= '0;
      page_q     <= '0;
      left_q     <= '0;
      aidx       <= '0;
      bcnt       <= '0;
      done       <= 1'b0;
      reject     <= 1'b0;
      run_fail   <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_ok) begin
              block_q  <= start_block;
              page_q   <= start_page;
              left_q   <= page_count;
              run_fail <= 1'b0;
              state    <= ST_CMD;
            end else begin
              reject <= 1'b1;
            end
          end
        end
        ST_CMD: begin
          aidx  <= '0;
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          if (aidx == 3'(ADDR_CYCLES - 1)) begin
            bcnt  <= '0;
            state <= ST_DATA;
          end else begin
            aidx <= aidx + 3'd1;
          end
        end
        ST_DATA: begin
          if (s_valid) begin
            bcnt <= bcnt + BYTE_W'(1);
            if (bcnt == LAST_BYTE) state <= ST_CONF;
          end
        end
        ST_CONF: state <= ST_SCMD;
        ST_SCMD: state <= ST_SRD;
        ST_SRD:  state <= ST_SCHK;
        ST_SCHK: begin
          if (st_ready) begin
            if (st_fail) begin
              run_fail   <= 1'b1;
              err_sticky <= 1'b1;
            end
            if (last_pg) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              page_q <= page_q + PG_W'(1);
              left_q <= left_q - CNT_W'(1);
              state  <= ST_CMD;
            end
          end else begin
            state <= ST_SRD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign s_ready  = (state == ST_DATA);
  assign nand_cle = (state == ST_CMD) || (state == ST_CONF) || (state == ST_SCMD);
  assign nand_ale = (state == ST_ADDR);
  assign nand_re  = (state == ST_SRD);
  assign nand_we  = nand_cle || nand_ale || ((state == ST_DATA) && s_valid);

  always_comb begin
    case (state)
      ST_CMD:  nand_dout = OP_LOAD;
      ST_ADDR: nand_dout = addr_byte;
      ST_DATA: nand_dout = s_data;
      ST_CONF: nand_dout = last_pg ? OP_FINAL_GO : OP_CACHE_GO;
      ST_SCMD: nand_dout = OP_STATUS;
      default: nand_dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker
  import cpc_pkg::*;
#(
  parameter int PAGE_BYTES = 8640
) (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we,
  input logic       nand_re,
  input logic [7:0] nand_dout,
  input logic [7:0] nand_din,
  input logic       busy,
  input logic       done,
  input logic       err_sticky,
  input logic       reject
);
  logic        cmd_wr;
  logic        data_wr;
  logic [31:0] data_cnt;
  logic        cache_wait;
  logic        re_q;

  assign cmd_wr  = nand_we && nand_cle;
  assign data_wr = nand_we && !nand_cle && !nand_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_cnt   <= '0;
      cache_wait <= 1'b0;
      re_q       <= 1'b0;
    end else begin
      re_q <= nand_re;
      if (cmd_wr && nand_dout == OP_LOAD) data_cnt <= '0;
      else if (data_wr) data_cnt <= data_cnt + 32'd1;
      if (cmd_wr && nand_dout == OP_CACHE_GO) cache_wait <= 1'b1;
      else if (re_q && nand_din[SB_CACHE_RDY]) cache_wait <= 1'b0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_we && nand_re) && !(nand_cle && nand_ale)); // R2

  AST_FULL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (nand_dout == OP_CACHE_GO || nand_dout == OP_FINAL_GO))
      |-> data_cnt == 32'(PAGE_BYTES)); // R3

  AST_CACHE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && nand_dout == OP_LOAD) |-> !cache_wait); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R6

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy && !nand_we && !nand_re); // R8

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R9
endmodule

bind cpc_cache_prog cpc_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we    (nand_we),
  .nand_re    (nand_re),
  .nand_dout  (nand_dout),
  .nand_din   (nand_din),
  .busy       (busy),
  .done       (done),
  .err_sticky (err_sticky),
  .reject     (reject)
);

// File: tb/sim_cpc_cache_prog.sv
module sim_cpc_cache_prog;
  localparam int PB  = 4;
  localparam int PPB = 4;
  localparam int BW  = 3;
  localparam int BLK = 5;
  localparam int PER = PB + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BW-1:0] start_block = '0;
  logic [1:0] start_page = '0;
  logic [2:0] page_count = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = '0;
  logic nand_cle, nand_ale, nand_we, nand_re;
  logic [7:0] nand_dout;
  logic [7:0] nand_din = '0;
  logic busy, done, run_fail, err_sticky, reject;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cpc_cache_prog #(.PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .BLOCK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_block(start_block),
    .start_page(start_page), .page_count(page_count),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re),
    .nand_dout(nand_dout), .nand_din(nand_din),
    .busy(busy), .done(done), .run_fail(run_fail), .err_sticky(err_sticky),
    .reject(reject)
  );

  function automatic logic [7:0] byte_fn(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // stream source
  int src_idx = 0;
  int src_total = 0;
  always @(negedge clk) begin
    s_valid <= (src_idx < src_total) && (cyc % 3 != 0);
    s_data  <= byte_fn(src_idx);
  end
  always @(posedge clk) if (s_valid && s_ready) src_idx <= src_idx + 1;

  // device model
  logic [9:0] lg [0:2047];
  int lw = 0, reads = 0, viol = 0, conf_n = 0, run_conf0 = 0, fail_at = -1;
  logic [7:0] fail_bits = '0, pend_fail = '0;
  int wait_cnt = 0;
  logic final_mode = 1'b0, cache_pend = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (nand_we) begin
        lg[lw] <= {nand_cle, nand_ale, nand_dout};
        lw <= lw + 1;
        if (nand_cle && nand_dout == 8'h80 && cache_pend) viol <= viol + 1;
        if (nand_cle && (nand_dout == 8'h15 || nand_dout == 8'h10)) begin
          final_mode <= (nand_dout == 8'h10);
          cache_pend <= 1'b1;
          wait_cnt   <= (nand_dout == 8'h10) ? 4 : ((conf_n == run_conf0) ? 1 : 3);
          pend_fail  <= (conf_n == fail_at) ? fail_bits : 8'h00;
          conf_n     <= conf_n + 1;
        end
      end
      if (nand_re) begin
        reads <= reads + 1;
        if (wait_cnt > 0) begin
          nand_din <= final_mode ? 8'h40 : 8'h00;
          wait_cnt <= wait_cnt - 1;
        end else begin
          nand_din   <= (final_mode ? 8'h60 : 8'h40) | pend_fail;
          cache_pend <= 1'b0;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_entry(int idx, int sp, int pc, int sb);
    int k = idx / PER;
    int o = idx % PER;
    int row = BLK * PPB + sp + k;
    if (o == 0) return {2'b10, 8'h80};
    if (o == 1 || o == 2) return {2'b01, 8'h00};
    if (o == 3) return {2'b01, 8'(row)};
    if (o == 4) return {2'b01, 8'(row >> 8)};
    if (o == 5) return {2'b01, 8'(row >> 16)};
    if (o < 6 + PB) return {2'b00, byte_fn(sb + k * PB + o - 6)};
    if (o == 6 + PB) return {2'b10, (k == pc - 1) ? 8'h10 : 8'h15};
    return {2'b10, 8'h70};
  endfunction

  function automatic string tag_of(int o);
    if (o == 0) return "R2";
    if (o >= 3 && o <= 5) return "R7";
    if (o < 6) return "R2";
    if (o < 6 + PB) return "R3";
    if (o == 6 + PB) return "R4";
    return "R5";
  endfunction

  task automatic run(int sp, int pc, int fidx, logic [7:0] fb, bit poke, bit exp_sticky);
    int lw0, rd0, vi0, sb, exp_rd, waitc;
    bit good, seen_done;
    good = (pc >= 1) && (sp + pc <= PPB);
    @(negedge clk);
    lw0 = lw; rd0 = reads; vi0 = viol;
    run_conf0 = conf_n;
    fail_at = (fidx >= 0) ? conf_n + fidx : -1;
    fail_bits = fb;
    sb = src_idx;
    if (good) src_total = src_idx + pc * PB;
    start = 1'b1; start_block = BW'(BLK); start_page = 2'(sp); page_count = 3'(pc);
    @(negedge clk);
    start = 1'b0;
    if (!good) begin
      check(reject == 1'b1 && busy == 1'b0, "R8 reject", int'(reject), 1);
      @(negedge clk);
      check(reject == 1'b0 && lw == lw0 && reads == rd0, "R8 quiet", lw - lw0, 0);
      return;
    end
    check(reject == 1'b0 && busy == 1'b1, "R8 accept", int'(busy), 1);
    seen_done = 0; waitc = 0;
    while (!seen_done && waitc < 2000) begin
      @(negedge clk);
      waitc++;
      if (poke && waitc == 7) begin
        start = 1'b1; start_page = 2'd0; page_count = 3'd1;
      end else start = 1'b0;
      if (done) seen_done = 1;
    end
    check(seen_done, "R6 done", int'(seen_done), 1);
    @(negedge clk);
    check(!busy && !done, "R6 pulse", int'(done), 0);
    check(lw - lw0 == pc * PER, poke ? "R10 length" : "R2 length", lw - lw0, pc * PER);
    for (int i = 0; i < pc * PER; i++) begin
      logic [9:0] e = exp_entry(i, sp, pc, sb);
      if (lg[lw0 + i] !== e) begin
        check(0, tag_of(i % PER), int'(lg[lw0 + i]), int'(e));
        break;
      end
    end
    checks++;
    exp_rd = 5;
    for (int k = 0; k < pc - 1; k++) exp_rd += (k == 0) ? 2 : 4;
    check(reads - rd0 == exp_rd, "R5 polls", reads - rd0, exp_rd);
    check(viol == vi0, "R5 early load", viol - vi0, 0);
    check(run_fail == (fidx >= 0), "R9 run_fail", int'(run_fail), int'(fidx >= 0));
    check(err_sticky == exp_sticky, "R9 sticky", int'(err_sticky), int'(exp_sticky));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !reject && !run_fail && !err_sticky && !s_ready &&
          !nand_we && !nand_re && !nand_cle && !nand_ale, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 R5 R6 R7 R8 sweep
    for (int sp = 0; sp < PPB; sp++)
      for (int pc = 0; pc <= PPB; pc++)
        run(sp, pc, -1, 8'h00, 1'b0, 1'b0);
    run(0, 3, -1, 8'h00, 1'b1, 1'b0);   // R10
    run(0, 4, 2, 8'h02, 1'b0, 1'b1);    // R9 previous-page fail bit
    run(1, 2, -1, 8'h00, 1'b0, 1'b1);   // R9 sticky holds, run_fail clears
    run(2, 1, 0, 8'h01, 1'b0, 1'b1);    // R9 current fail bit
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule